// File: doc/BRIEF.md
# Earliest-of-Three-Peaks Symbol Timing Locator

This block picks the start of the FFT window for a multicarrier receiver. Its input is the magnitude stream from a correlator matched to the repeating training pattern at the head of a packet. A window placed at the single strongest correlation peak lets multipath energy from the following symbol spill into the FFT interval. The block avoids that. During a search it keeps the three strongest samples, ranked by magnitude, together with the arrival index of each.

When the search is closed, the block takes the earliest-arriving of the retained peaks and moves back from it by a programmable number of samples. It reports the result with a one-cycle completion strobe. A controller opens the search with a start pulse, feeds magnitudes with a valid strobe, and closes the search with an end pulse.

Top module: `peak3_timing_locator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `timing_done` is 0 and `timing_idx` is 0.
- R2: A `srch_start` pulse opens a new search, even if one is already open. It empties the peak list and restarts the sample index at 0. A sample presented in the same cycle as `srch_start` is not ranked.
- R3: Only samples with `mag_valid` high inside an open search are ranked. The k-th such sample has index k-1. The index saturates at 2^IDX_W-1.
- R4: The retained list holds the three largest ranked magnitudes. The result is based on the smallest index among them.
- R5: A new magnitude displaces a retained entry only if it is strictly larger, so equal magnitudes keep the earlier-arriving entry.
- R6: If fewer than three samples were ranked, only the filled entries are considered. With no ranked samples the earliest index is taken as 0.
- R7: `timing_idx` equals the earliest index minus `backoff`, saturating at 0 when `backoff` is equal to or larger than that index.
- R8: `timing_done` is a one-cycle pulse in the cycle after `srch_end` is sampled in an open search, and the search then closes. An `srch_end` outside a search is ignored. If `srch_start` is high in the same cycle, `srch_end` is ignored.
- R9: A valid sample presented in the same cycle as an accepted `srch_end` takes part in the ranking.
- R10: `timing_idx` holds its value between `timing_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mag_valid | input | 1 | `mag_in` carries a sample this cycle |
| mag_in | input | MAG_W | Correlator magnitude |
| srch_start | input | 1 | Open a new search |
| srch_end | input | 1 | Close the search and produce a result |
| backoff | input | OFS_W | Samples to move back from the earliest peak |
| timing_idx | output | IDX_W | Chosen window start index |
| timing_done | output | 1 | One-cycle strobe, `timing_idx` is new |

## Verification
The bench builds the block with MAG_W=8, IDX_W=6 and OFS_W=5. The narrow index makes saturation reachable within one search of about seventy samples. A five-bit backoff can equal or exceed the peak indices, which exercises both the clamped and the normal subtraction. The eight-bit magnitudes make ties frequent in the random phase, so the earlier-wins rule is exercised often, not only in the directed cases.

// File: rtl/peak3_timing_locator.sv
module peak3_timing_locator #(
  parameter int MAG_W = 16,
  parameter int IDX_W = 10,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mag_valid,
  input  logic [MAG_W-1:0] mag_in,
  input  logic             srch_start,
  input  logic             srch_end,
  input  logic [OFS_W-1:0] backoff,
  output logic [IDX_W-1:0] timing_idx,
  output logic             timing_done
);
  localparam int SLOTS = 3;
  localparam int DW = (IDX_W > OFS_W) ? IDX_W : OFS_W;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             searching;
  logic [IDX_W-1:0] cnt;
  logic [MAG_W-1:0] mag_q [SLOTS];
  logic [IDX_W-1:0] idx_q [SLOTS];
  logic [SLOTS-1:0] vld_q;
  logic [MAG_W-1:0] mag_d [SLOTS];
  logic [IDX_W-1:0] idx_d [SLOTS];
  logic [SLOTS-1:0] vld_d;
  logic [IDX_W-1:0] earliest;
  logic [DW-1:0]    e_ext, b_ext;
  logic [IDX_W-1:0] result;

  wire take   = searching && mag_valid && !srch_start;
  wire finish = searching && srch_end && !srch_start;

  always_comb begin
    int pos;
    pos = SLOTS;
    for (int j = SLOTS - 1; j >= 0; j--)
      if (!vld_q[j] || mag_in > mag_q[j]) pos = j;
    for (int j = 0; j < SLOTS; j++) begin
      mag_d[j] = mag_q[j];
      idx_d[j] = idx_q[j];
      vld_d[j] = vld_q[j];
      if (take && j == pos) begin
        mag_d[j] = mag_in;
        idx_d[j] = cnt;
        vld_d[j] = 1'b1;
      end else if (take && j > pos) begin
        mag_d[j] = mag_q[j-1];
        idx_d[j] = idx_q[j-1];
        vld_d[j] = vld_q[j-1];
      end
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    earliest = '0;
    for (int j = 0; j < SLOTS; j++)
      if (vld_d[j] && (!found || idx_d[j] < earliest)) begin
        earliest = idx_d[j];
        found = 1'b1;
      end
  end

  assign e_ext  = DW'(earliest);
  assign b_ext  = DW'(backoff);
  assign result = (e_ext > b_ext) ? IDX_W'(e_ext - b_ext) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      searching   <= 1'b0;
      cnt         <= '0;
      vld_q       <= '0;
      timing_idx  <= '0;
      timing_done <= 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        mag_q[j] <= '0;
        idx_q[j] <= '0;
      end
    end else begin
      timing_done <= finish;
      if (finish) timing_idx <= result;
      if (srch_start) begin
        searching <= 1'b1;
        cnt       <= '0;
        vld_q     <= '0;
      end else begin
        if (take) begin
          for (int j = 0; j < SLOTS; j++) begin
            mag_q[j] <= mag_d[j];
            idx_q[j] <= idx_d[j];
          end
          vld_q <= vld_d;
          if (cnt != IDX_MAX) cnt <= cnt + 1'b1;
        end
        if (finish) searching <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/peak3_timing_locator_chk.sv
module peak3_timing_locator_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mag_valid,
  input logic             srch_start,
  input logic             srch_end,
  input logic             searching,
  input logic [IDX_W-1:0] cnt,
  input logic [IDX_W-1:0] timing_idx,
  input logic             timing_done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !timing_done);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_done |=> !timing_done);
  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_done |-> $past(srch_end && searching && !srch_start));
  // R8
  idle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_end && !searching && !srch_start) |=> !timing_done);
  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_done |-> $stable(timing_idx));
  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_start |=> (cnt == '0 && searching));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (searching && mag_valid && !srch_start && cnt != '1) |=> cnt == IDX_W'($past(cnt) + 1'b1));
endmodule

bind peak3_timing_locator peak3_timing_locator_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mag_valid(mag_valid), .srch_start(srch_start),
  .srch_end(srch_end), .searching(searching), .cnt(cnt),
  .timing_idx(timing_idx), .timing_done(timing_done));

// File: tb/peak3_timing_locator_bench.sv
module peak3_timing_locator_bench;
  localparam int MAG_W = 8, IDX_W = 6, OFS_W = 5;
  localparam int IMAX = (1 << IDX_W) - 1;

  logic clk = 0, rst_n = 0;
  logic mag_valid = 0, srch_start = 0, srch_end = 0;
  logic [MAG_W-1:0] mag_in = '0;
  logic [OFS_W-1:0] backoff = '0;
  logic [IDX_W-1:0] timing_idx;
  logic timing_done;

  int checks = 0, errors = 0;
  string tag = "R1";

  bit act = 0;
  int cnt = 0;
  int q_mag[$], q_idx[$];
  int exp_idx = 0;
  bit exp_done = 0;

  always #10 clk = ~clk;

  peak3_timing_locator #(.MAG_W(MAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_peak3_timing_locator (
    .clk(clk), .rst_n(rst_n), .mag_valid(mag_valid), .mag_in(mag_in),
    .srch_start(srch_start), .srch_end(srch_end), .backoff(backoff),
    .timing_idx(timing_idx), .timing_done(timing_done));

  task automatic compare();
    checks++;
    if (timing_done !== exp_done || timing_idx !== IDX_W'(exp_idx)) begin
      errors++;
      $display("FAIL %s: done=%0b idx=%0d expected done=%0b idx=%0d",
               tag, timing_done, timing_idx, exp_done, exp_idx);
    end
  endtask

  function automatic int pick_result(int bo);
    int m[$], ix[$], best, early;
    m = q_mag; ix = q_idx;
    early = -1;
    for (int k = 0; k < 3 && m.size() > 0; k++) begin
      best = 0;
      for (int i = 1; i < m.size(); i++)
        if (m[i] > m[best]) best = i;
      if (early < 0 || ix[best] < early) early = ix[best];
      m.delete(best); ix.delete(best);
    end
    if (early < 0) early = 0;
    return (early > bo) ? early - bo : 0;
  endfunction

  task automatic step(bit s, bit e, bit v, int m);
    bit fin, tk;
    @(negedge clk);
    srch_start = s; srch_end = e; mag_valid = v; mag_in = MAG_W'(m);
    @(posedge clk);
    fin = act && e && !s;
    tk  = act && v && !s;
    if (tk) begin
      q_mag.push_back(m); q_idx.push_back(cnt);
      if (cnt < IMAX) cnt++;
    end
    if (fin) begin exp_done = 1; exp_idx = pick_result(int'(backoff)); end
    else exp_done = 0;
    if (s) begin act = 1; cnt = 0; q_mag.delete(); q_idx.delete(); end
    else if (fin) act = 0;
    #1 compare();
  endtask

  task automatic feed(int m); step(0, 0, 1, m); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 compare();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 compare();

    // R4 top three, earliest of them
    tag = "R4"; backoff = 0;
    step(1, 0, 0, 0);
    feed(10); feed(50); feed(30); feed(80); feed(20); feed(70);
    step(0, 1, 0, 0); idle(2);

    // R7 normal subtraction: earliest 4, backoff 3 -> 1
    tag = "R7"; backoff = 3;
    step(1, 0, 0, 0);
    feed(1); feed(2); feed(3); feed(4); feed(90); feed(5); feed(95); feed(99);
    step(0, 1, 0, 0); idle(1);
    // R7 backoff equal to index and larger than index
    backoff = 4;
    step(1, 0, 0, 0); feed(1); feed(2); feed(3); feed(4); feed(90); feed(95); feed(99);
    step(0, 1, 0, 0); idle(1);
    backoff = 31;
    step(1, 0, 0, 0); feed(9); feed(200); feed(201); feed(202);
    step(0, 1, 0, 0); idle(1);

    // R5 ties keep earlier entries
    tag = "R5"; backoff = 0;
    step(1, 0, 0, 0);
    feed(5); feed(60); feed(60); feed(60); feed(60); feed(60);
    step(0, 1, 0, 0); idle(1);
    step(1, 0, 0, 0);
    feed(3); feed(3); feed(100); feed(40); feed(100); feed(40); feed(100);
    step(0, 1, 0, 0); idle(1);

    // R6 partial list and empty list
    tag = "R6"; backoff = 1;
    step(1, 0, 0, 0); idle(2); feed(7); feed(8);
    step(0, 1, 0, 0); idle(1);
    backoff = 0;
    step(1, 0, 0, 0); idle(3); step(0, 1, 0, 0); idle(1);

    // R3 gaps in valid, samples outside search, index saturation
    tag = "R3";
    feed(250); feed(251);
    step(1, 0, 0, 0);
    feed(10); idle(3); feed(11); step(0, 0, 0, 200); feed(12);
    step(0, 1, 0, 0); idle(1);
    step(1, 0, 0, 0);
    for (int i = 0; i < 70; i++) feed(i < 60 ? 20 : 100 + i);
    step(0, 1, 0, 0); idle(1);

    // R2 restart mid search, sample with start is ignored
    tag = "R2";
    step(1, 0, 0, 0); feed(200); feed(201);
    step(1, 0, 1, 255); feed(9); feed(8);
    step(0, 1, 0, 0); idle(1);

    // R8 end while idle, end with start, back-to-back searches
    tag = "R8";
    step(0, 1, 0, 0); idle(2);
    step(1, 1, 0, 0); feed(40); feed(41);
    step(0, 1, 0, 0); step(1, 0, 0, 0); feed(50); step(0, 1, 0, 0); idle(1);

    // R9 sample on the closing cycle is ranked
    tag = "R9"; backoff = 0;
    step(1, 0, 0, 0); feed(10); feed(11); feed(12); feed(13);
    step(0, 1, 1, 250); idle(1);

    // R10 output holds across idle and an open search
    tag = "R10";
    idle(4); step(1, 0, 0, 0); feed(30); idle(3); step(0, 1, 0, 0); idle(2);

    // random mix
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (n % 200 == 0) backoff = OFS_W'($urandom_range(0, 31));
      step(r < 3, r >= 3 && r < 7, $urandom_range(0, 3) != 0, $urandom_range(0, 15) * 16);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule